// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling ADC Readout Sequencer

This block runs on the host side of a dual-channel, 14-bit, simultaneous-sampling converter that has a parallel data bus. When `start` is seen in the idle state, the block drives the active-low convert-start line for a fixed number of cycles. It then waits until the converter's busy line has been high and has fallen again. After that it performs two back-to-back bus reads with a shared chip-select and a read strobe. The first read returns channel A and the second returns channel B. Both results are presented together with a one-cycle valid pulse. A quiet interval then follows before the next conversion can begin.

Every interval is a count of system-clock cycles. Each count is derived by ceiling division from a nanosecond parameter and the clock frequency, so no interval can fall below its minimum. A parameter chooses how the 14-bit codes are widened to 16 bits: sign extension for bipolar (two's complement) ranges or zero fill for the unipolar (straight binary) range. The `pd_mode` input is latched with `start` and selects the longer busy budget that applies when the converter sleeps between conversions. If busy does not complete its high-then-low cycle within twice the conversion time for the latched mode, the block raises a one-cycle error and returns to idle without reading.

Top module: `dual_adc_seq`

## Requirements
- R1: During and right after reset, `adc_convst_n`, `adc_cs_n` and `adc_rd_n` are 1, `res_valid` and `timeout_err` are 0, and both results are 0.
- R2: `start` sampled high in idle drives `adc_convst_n` low from the next cycle for exactly ceil(35 ns × f) cycles (4 at 100 MHz).
- R3: No read starts until busy has been sampled high and then sampled low. The first read strobe falls in the cycle after busy is first sampled low.
- R4: Each read holds `adc_cs_n` and `adc_rd_n` low together for max(ceil(45 ns × f), ceil(30 ns × f)) cycles (5 at 100 MHz). Data is captured at the clock edge that ends the last low cycle.
- R5: Between the two reads, `adc_rd_n` is high for ceil(10 ns × f) cycles (1) while `adc_cs_n` stays low.
- R6: The first read goes to `res_a` and the second to `res_b`. Both outputs update together, in the cycle where `res_valid` pulses for one cycle and `adc_rd_n` returns high. Both hold their value at all other times.
- R7: With `SIGNED_OUT`=1, data bit 13 is replicated into bits 15:14. With `SIGNED_OUT`=0, bits 15:14 are 0.
- R8: After the valid cycle, `adc_convst_n` stays high for at least ceil(max(400 ns, 500 ns) × f) cycles (50). This holds even when `start` is held high.
- R9: `start` (and `pd_mode`) are ignored outside idle and do not change a running sequence.
- R10: With `pd_mode` latched as 0, if busy does not complete within 2 × ceil(5.2 µs × f) cycles (1040) of entering the wait, `timeout_err` pulses for one cycle. No read takes place, the block returns to idle, and the results are unchanged. The pulse comes 1044 cycles after the first low cycle of convert-start.
- R11: With `pd_mode` latched as 1 at `start`, the busy budget is 2 × ceil(10 µs × f) cycles (2000). A busy lasting 1500 cycles completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion-and-readout sequence |
| pd_mode | input | 1 | Converter sleeps between conversions; latched with start |
| adc_busy | input | 1 | Converter busy indication |
| adc_data | input | RAW_W (14) | Converter parallel data bus |
| adc_convst_n | output | 1 | Active-low convert-start |
| adc_cs_n | output | 1 | Active-low chip-select |
| adc_rd_n | output | 1 | Active-low read strobe |
| res_a | output | OUT_W (16) | Extended channel A result |
| res_b | output | OUT_W (16) | Extended channel B result |
| res_valid | output | 1 | One-cycle pulse: new result pair |
| timeout_err | output | 1 | One-cycle pulse: busy did not complete |

## Verification
Counting from the edge that samples `start` as cycle 0, convert-start is low in cycles 0 to 3. If busy is first sampled low at the edge of cycle L+1, the strobes are low in cycles L+1 to L+5 and L+7 to L+11, the gap falls in cycle L+6, and valid together with both results comes in cycle L+12. The earliest next convert-start is cycle L+63, and a timeout pulse lands in cycle 1044 or 2004. The bench builds that timeline for every transaction as a queue of expected strobe vectors and checks one entry at each falling clock edge. Converter data stays invalid until the strobe has been low for three sampled cycles, so an early capture shows up as a wrong result.

// File: rtl/dual_adc_seq.sv
module dual_adc_seq #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int RAW_W      = 14,
  parameter int OUT_W      = 16,
  parameter bit SIGNED_OUT = 1'b1,
  parameter int CONVST_NS  = 35,
  parameter int CONV_NS    = 5200,
  parameter int PD_CONV_NS = 10000,
  parameter int RD_NS      = 45,
  parameter int ACCESS_NS  = 30,
  parameter int GAP_NS     = 10,
  parameter int QUIET_NS   = 400,
  parameter int ACQ_NS     = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pd_mode,
  input  logic             adc_busy,
  input  logic [RAW_W-1:0] adc_data,
  output logic             adc_convst_n,
  output logic             adc_cs_n,
  output logic             adc_rd_n,
  output logic [OUT_W-1:0] res_a,
  output logic [OUT_W-1:0] res_b,
  output logic             res_valid,
  output logic             timeout_err
);

  function automatic int cyc(input longint ns);
    longint t;
    t = (ns * longint'(CLK_HZ) + 64'sd999_999_999) / 64'sd1_000_000_000;
    return (t < 1) ? 1 : int'(t);
  endfunction

  localparam int N_CV    = cyc(longint'(CONVST_NS));
  localparam int N_RD    = (cyc(longint'(RD_NS)) > cyc(longint'(ACCESS_NS))) ?
                           cyc(longint'(RD_NS)) : cyc(longint'(ACCESS_NS));
  localparam int N_GAP   = cyc(longint'(GAP_NS));
  localparam int N_QT    = cyc(longint'((QUIET_NS > ACQ_NS) ? QUIET_NS : ACQ_NS));
  localparam int TMO_N   = 2 * cyc(longint'(CONV_NS));
  localparam int TMO_P   = 2 * cyc(longint'(PD_CONV_NS));
  localparam int TMO_MAX = (TMO_N > TMO_P) ? TMO_N : TMO_P;
  localparam int CW      = $clog2(TMO_MAX + 1);
  localparam int PAD     = OUT_W - RAW_W;

  typedef enum logic [2:0] {
    S_IDLE, S_CONV, S_WAIT, S_RD_A, S_GAP, S_RD_B, S_QUIET
  } st_t;

  st_t            state, nstate;
  logic [CW-1:0]  cnt, lim;
  logic           last, seen, pd_q, bus_done;
  logic [OUT_W-1:0] ext, a_hold;

  assign ext      = SIGNED_OUT ? {{PAD{adc_data[RAW_W-1]}}, adc_data}
                               : {{PAD{1'b0}}, adc_data};
  assign last     = (cnt == lim - CW'(1));
  assign bus_done = seen && !adc_busy;

  always_comb begin
    case (state)
      S_CONV:         lim = CW'(N_CV);
      S_WAIT:         lim = pd_q ? CW'(TMO_P) : CW'(TMO_N);
      S_RD_A, S_RD_B: lim = CW'(N_RD);
      S_GAP:          lim = CW'(N_GAP);
      S_QUIET:        lim = CW'(N_QT);
      default:        lim = CW'(1);
    endcase
  end

  always_comb begin
    nstate = state;
    case (state)
      S_IDLE:  if (start) nstate = S_CONV;
      S_CONV:  if (last) nstate = S_WAIT;
      S_WAIT:  if (bus_done) nstate = S_RD_A;
               else if (last) nstate = S_IDLE;
      S_RD_A:  if (last) nstate = S_GAP;
      S_GAP:   if (last) nstate = S_RD_B;
      S_RD_B:  if (last) nstate = S_QUIET;
      S_QUIET: if (last) nstate = S_IDLE;
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cnt          <= '0;
      seen         <= 1'b0;
      pd_q         <= 1'b0;
      adc_convst_n <= 1'b1;
      adc_cs_n     <= 1'b1;
      adc_rd_n     <= 1'b1;
      a_hold       <= '0;
      res_a        <= '0;
      res_b        <= '0;
      res_valid    <= 1'b0;
      timeout_err  <= 1'b0;
    end else begin
      state <= nstate;
      cnt   <= (nstate != state || state == S_IDLE) ? '0 : cnt + CW'(1);
      if (state == S_IDLE && start) begin
        pd_q <= pd_mode;
        seen <= 1'b0;
      end else if ((state == S_CONV || state == S_WAIT) && adc_busy) begin
        seen <= 1'b1;
      end
      adc_convst_n <= (nstate != S_CONV);
      adc_cs_n     <= !(nstate == S_RD_A || nstate == S_GAP || nstate == S_RD_B);
      adc_rd_n     <= !(nstate == S_RD_A || nstate == S_RD_B);
      if (state == S_RD_A && last) a_hold <= ext;
      res_valid    <= (state == S_RD_B) && last;
      if (state == S_RD_B && last) begin
        res_a <= a_hold;
        res_b <= ext;
      end
      timeout_err  <= (state == S_WAIT) && last && !bus_done;
    end
  end

endmodule

// File: rtl/dual_adc_seq_chk.sv
module dual_adc_seq_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_busy,
  input logic             adc_convst_n,
  input logic             adc_cs_n,
  input logic             adc_rd_n,
  input logic [OUT_W-1:0] res_a,
  input logic [OUT_W-1:0] res_b,
  input logic             res_valid,
  input logic             timeout_err
);

  p_rd_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !adc_cs_n);

  p_no_convst_on_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> adc_convst_n);

  p_read_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rd_n) |-> !$past(adc_busy));

  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_valid_at_read_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (adc_rd_n && $past(!adc_rd_n)));

  p_res_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_a) && $stable(res_b)));

  p_timeout_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (adc_cs_n && adc_convst_n && !res_valid));

  p_timeout_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err);

endmodule

bind dual_adc_seq dual_adc_seq_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_busy(adc_busy),
  .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
  .res_a(res_a), .res_b(res_b), .res_valid(res_valid), .timeout_err(timeout_err)
);

// File: tb/test_dual_adc_seq.sv
module test_dual_adc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO_N = 1040;
  localparam int TMO_P = 2000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pd_mode = 1'b0, adc_busy = 1'b0;
  logic [13:0] adc_data = '0;
  logic s_cv, s_cs, s_rd, s_val, s_err, u_cv, u_cs, u_rd, u_val, u_err;
  logic [15:0] s_a, s_b, u_a, u_b;

  dual_adc_seq i_dual_adc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pd_mode(pd_mode),
    .adc_busy(adc_busy), .adc_data(adc_data),
    .adc_convst_n(s_cv), .adc_cs_n(s_cs), .adc_rd_n(s_rd),
    .res_a(s_a), .res_b(s_b), .res_valid(s_val), .timeout_err(s_err));

  dual_adc_seq #(.SIGNED_OUT(1'b0)) i_dual_adc_seq_u (
    .clk(clk), .rst_n(rst_n), .start(start), .pd_mode(pd_mode),
    .adc_busy(adc_busy), .adc_data(adc_data),
    .adc_convst_n(u_cv), .adc_cs_n(u_cs), .adc_rd_n(u_rd),
    .res_a(u_a), .res_b(u_b), .res_valid(u_val), .timeout_err(u_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [4:0] q_v[$];
  string      q_t[$];
  logic [15:0] last_a = '0, last_b = '0;

  function automatic logic [15:0] sx(input logic [13:0] v);
    return {{2{v[13]}}, v};
  endfunction
  function automatic logic [15:0] zx(input logic [13:0] v);
    return {2'b00, v};
  endfunction

  task automatic chk_vec(input logic [4:0] exp, input string tag);
    logic [4:0] got;
    got = {s_cv, s_cs, s_rd, s_val, s_err};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s strobes {cv,cs,rd,val,err} got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk16(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s result got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic push(input int n, input logic [4:0] v, input string t);
    for (int i = 0; i < n; i++) begin
      q_v.push_back(v);
      q_t.push_back(t);
    end
  endtask

  // Expected timeline: sample k is the falling edge after the k-th rising edge.
  task automatic build(input int L, input bit pd, input bit poke);
    string tw;
    tw = pd ? "R11" : (L < 0 ? "R10" : "R3");
    if (poke) tw = "R9";
    push(4, 5'b01100, poke ? "R9" : "R2");
    if (L < 0) begin
      push(pd ? TMO_P : TMO_N, 5'b11100, tw);
      push(1, 5'b11101, tw);
    end else begin
      push(L - 3, 5'b11100, tw);
      push(5, 5'b10000, poke ? "R9" : "R4");
      push(1, 5'b10100, poke ? "R9" : "R5");
      push(5, 5'b10000, poke ? "R9" : "R4");
      push(1, 5'b11110, poke ? "R9" : "R6");
      push(50, 5'b11100, poke ? "R9" : "R8");
    end
  endtask

  task automatic run(input int L, input bit pd, input logic [13:0] a,
                     input logic [13:0] b, input bit hold, input bit poke);
    int k = 0, lowcnt = 0, ridx = 0;
    start = 1'b1;
    pd_mode = pd;
    build(L, pd, poke);
    @(posedge clk);
    while (q_v.size() > 0) begin
      @(negedge clk);
      if (!hold) start = 1'b0;
      if (poke) begin
        start   = (k % 7 == 3);
        pd_mode = ~pd;
      end
      chk_vec(q_v.pop_front(), q_t.pop_front());
      if (L >= 0 && k == L + 12) begin
        chk16("R6", s_a, sx(a));
        chk16("R6", s_b, sx(b));
        chk16("R7", u_a, zx(a));
        chk16("R7", u_b, zx(b));
        last_a = sx(a);
        last_b = sx(b);
      end
      if (L < 0 && q_v.size() == 0) begin
        chk16("R10", s_a, last_a);
        chk16("R10", s_b, last_b);
      end
      if (k == 0) adc_busy = 1'b1;
      if (L >= 0 && k == L) adc_busy = 1'b0;
      if (!s_rd) lowcnt++;
      else begin
        if (lowcnt > 0) ridx++;
        lowcnt = 0;
      end
      adc_data = (lowcnt >= 3) ? ((ridx == 0) ? a : b) : 14'h2AAA;
      k++;
    end
    if (L < 0) adc_busy = 1'b0;
    if (!hold) start = 1'b0;
    pd_mode = 1'b0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_vec(5'b11100, "R1");
    chk16("R1", s_a, 16'h0);
    chk16("R1", s_b, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_vec(5'b11100, "R1");
    run(20,   1'b0, 14'h1234, 14'h3ABC, 1'b0, 1'b0);
    run(4,    1'b0, 14'h2000, 14'h1FFF, 1'b1, 1'b0);
    run(12,   1'b0, 14'h0001, 14'h3FFF, 1'b0, 1'b0);
    run(30,   1'b0, 14'h0ABC, 14'h2555, 1'b0, 1'b1);
    run(-1,   1'b0, 14'h0000, 14'h0000, 1'b0, 1'b0);
    run(1500, 1'b1, 14'h3000, 14'h0FFF, 1'b0, 1'b0);
    run(-1,   1'b1, 14'h0000, 14'h0000, 1'b0, 1'b0);
    run(8,    1'b0, 14'h2001, 14'h0002, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk_vec(5'b11100, "R9");
    finish_up();
  end
endmodule